// File: doc/BRIEF.md
# Branch Compare and Next-PC Unit

This unit sits in the execute stage of a 32-bit RISC-V style core. It has no condition-code flags. Each conditional branch compares two register operands directly, in a signed or an unsigned sense, and the same comparator produces the 0/1 outcome of the set-less-than operations. From the current program counter it forms three values: the sequential address, the branch target and the PC-relative upper-immediate sum. It then chooses the next PC and updates its own PC register.

Decode supplies the operation select, the two operands and an immediate that is already sign-extended to 32 bits. For branches the immediate counts half-words. For the compare-with-immediate operations it is the sign-extended 12-bit value. For the upper-immediate operation its low 20 bits are used. Greater-than and less-or-equal branches have no codes of their own: decode swaps the operands and issues less-than or greater-or-equal. The input strobe `in_valid` carries no back-pressure because the unit accepts one operation every cycle. The outputs are combinational from the current inputs and the PC register. The PC register loads `next_pc` on each cycle in which the strobe is high.

Top module: `branch_pc_unit`

## Requirements
- R1: A synchronous reset, active high on `rst`, loads the PC register with parameter RESET_VEC (default 0x0000_1000).
- R2: On a clock edge with `in_valid` high, `pc` takes the value `next_pc` showed before that edge. With `in_valid` low, `pc` holds.
- R3: Op 1 (equal) and op 2 (not equal) set `taken` from bitwise equality of `rs1_val` and `rs2_val`, with no regard to sign.
- R4: Op 3 (signed less) and op 4 (signed greater-or-equal) compare the operands as two's complement, so 0xFFFFFFFF counts as -1.
- R5: Op 5 (unsigned less) and op 6 (unsigned greater-or-equal) compare the operands as unsigned, so 0xFFFFFFFF counts as 4294967295.
- R6: Driving op 3 or op 6 with the operands swapped gives signed greater-than and unsigned less-or-equal of the original pair.
- R7: When a branch is taken, `next_pc` = `pc` + (`imm` × 2). The offset is signed, so a negative offset targets a lower address.
- R8: When no branch is taken, `taken` is 0 and `next_pc` = `pc` + 4. This covers a branch whose condition fails, op 0 (no branch), ops 7 to 11, and undefined codes 12 to 15.
- R9: Op 7 (signed) and op 8 (unsigned) drive `result` to 1 when `rs1_val` < `rs2_val` and to 0 otherwise.
- R10: Op 9 (signed) and op 10 (unsigned) compare `rs1_val` against `imm`. An immediate of -1 therefore compares as 0xFFFFFFFF under op 10.
- R11: Op 11 drives `result` to `pc` + (`imm`[19:0] << 12). An immediate of zero returns `pc`.
- R12: With COMPRESSED = 0, `misaligned` is 1 exactly when a branch is taken and bit 1 of its target is set. The PC still loads that target.
- R13: For ops 0 to 6 and for undefined codes, `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present; the PC register advances |
| op | input | 4 | Decoded operation select |
| rs1_val | input | 32 | First register operand |
| rs2_val | input | 32 | Second register operand |
| imm | input | 32 | Sign-extended immediate |
| pc | output | 32 | Current PC register |
| taken | output | 1 | Branch condition holds |
| next_pc | output | 32 | Address the PC register loads next |
| result | output | 32 | Set-less-than or upper-immediate result |
| misaligned | output | 1 | Taken target not on a 4-byte boundary |

## Verification
The assertions assume that `op`, the operands, `imm` and `in_valid` hold known values on every clock edge outside reset. They also assume that reset is asserted from time zero, so that the PC register starts at a defined value. The stimulus drives every input from time zero, changes inputs only on falling edges, and keeps reset high for the first cycles. It sweeps all 16 operation codes across a grid of corner operands: zero, one, the signed extremes, all-ones and neighbours of these. Immediates cycle through the 12-bit extremes and through odd and even offsets.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_BEQ   = 4'd1,
    OP_BNE   = 4'd2,
    OP_BLT   = 4'd3,
    OP_BGE   = 4'd4,
    OP_BLTU  = 4'd5,
    OP_BGEU  = 4'd6,
    OP_SLT   = 4'd7,
    OP_SLTU  = 4'd8,
    OP_SLTI  = 4'd9,
    OP_SLTIU = 4'd10,
    OP_AUIPC = 4'd11
  } bpu_op_e;

  localparam int OP_W = 4;

  function automatic logic op_is_branch(input logic [OP_W-1:0] o);
    return (o >= 4'd1) && (o <= 4'd6);
  endfunction

  function automatic logic op_is_set(input logic [OP_W-1:0] o);
    return (o >= 4'd7) && (o <= 4'd10);
  endfunction

  function automatic logic op_uses_imm(input logic [OP_W-1:0] o);
    return (o == 4'd9) || (o == 4'd10);
  endfunction
endpackage

// File: rtl/bpu_compare.sv
module bpu_compare #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq,
  output logic         lt_s,
  output logic         lt_u
);
  localparam int MSB = W - 1;

  logic [W:0] diff;

  always_comb begin
    diff = {1'b0, a} - {1'b0, b};
    eq   = (a == b);
    lt_u = diff[W];
    // differing signs: the negative one is smaller
    lt_s = (a[MSB] != b[MSB]) ? a[MSB] : lt_u;
  end

  always_comb begin
    if (eq) begin
      a_r3_eq_not_less: assert (!lt_s && !lt_u);
    end
    if (lt_u && (a[MSB] == b[MSB])) begin
      a_r4_same_sign_agree: assert (lt_s);
    end
  end
endmodule

// File: rtl/bpu_cond.sv
module bpu_cond
  import bpu_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            eq,
  input  logic            lt_s,
  input  logic            lt_u,
  output logic            take,
  output logic            set_bit
);
  always_comb begin
    take = 1'b0;
    unique case (op)
      OP_BEQ:  take = eq;
      OP_BNE:  take = !eq;
      OP_BLT:  take = lt_s;
      OP_BGE:  take = !lt_s;
      OP_BLTU: take = lt_u;
      OP_BGEU: take = !lt_u;
      default: take = 1'b0;
    endcase
  end

  always_comb begin
    set_bit = 1'b0;
    unique case (op)
      OP_SLT, OP_SLTI:   set_bit = lt_s;
      OP_SLTU, OP_SLTIU: set_bit = lt_u;
      default:           set_bit = 1'b0;
    endcase
  end
endmodule

// File: rtl/bpu_target.sv
module bpu_target #(
  parameter int W          = 32,
  parameter bit COMPRESSED = 1'b0
) (
  input  logic [W-1:0] pc,
  input  logic [W-1:0] imm,
  input  logic         take,
  output logic [W-1:0] next_pc,
  output logic [W-1:0] upper_sum,
  output logic         misaligned
);
  localparam int INSN_BYTES = 4;
  localparam int UPPER_SH   = 12;
  localparam int UPPER_W    = 20;

  logic [W-1:0] seq_pc;
  logic [W-1:0] br_pc;

  always_comb begin
    seq_pc    = pc + W'(INSN_BYTES);
    br_pc     = pc + {imm[W-2:0], 1'b0};
    upper_sum = pc + {imm[UPPER_W-1:0], {UPPER_SH{1'b0}}};
    next_pc   = take ? br_pc : seq_pc;
  end

  generate
    if (COMPRESSED) begin : g_half
      assign misaligned = 1'b0;
    end else begin : g_word
      assign misaligned = take & br_pc[1];
    end
  endgenerate
endmodule

// File: rtl/branch_pc_unit.sv
module branch_pc_unit
  import bpu_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter logic [31:0] RESET_VEC  = 32'h0000_1000,
  parameter bit          COMPRESSED = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [3:0]      op,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  input  logic [XLEN-1:0] imm,
  output logic [XLEN-1:0] pc,
  output logic            taken,
  output logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] result,
  output logic            misaligned
);
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] cmp_b;
  logic [XLEN-1:0] upper_sum;
  logic            eq, lt_s, lt_u, take, set_bit;

  assign cmp_b = op_uses_imm(op) ? imm : rs2_val;

  bpu_compare #(.W(XLEN)) u_cmp (
    .a(rs1_val), .b(cmp_b), .eq(eq), .lt_s(lt_s), .lt_u(lt_u)
  );

  bpu_cond u_cond (
    .op(op), .eq(eq), .lt_s(lt_s), .lt_u(lt_u), .take(take), .set_bit(set_bit)
  );

  bpu_target #(.W(XLEN), .COMPRESSED(COMPRESSED)) u_tgt (
    .pc(pc_q), .imm(imm), .take(take), .next_pc(next_pc),
    .upper_sum(upper_sum), .misaligned(misaligned)
  );

  always_comb begin
    if (op == OP_AUIPC)  result = upper_sum;
    else if (op_is_set(op)) result = {{(XLEN-1){1'b0}}, set_bit};
    else                 result = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)           pc_q <= XLEN'(RESET_VEC);
    else if (in_valid) pc_q <= next_pc;
  end

  assign pc    = pc_q;
  assign taken = take;

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> $stable(pc_q));
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid)) |-> (pc_q == $past(next_pc)));
  a_r8_sequential: assert property (@(posedge clk) disable iff (rst)
    !taken |-> (next_pc == pc_q + XLEN'(4)));
  a_r8_only_branches: assert property (@(posedge clk) disable iff (rst)
    taken |-> op_is_branch(op));
  a_r12_flag: assert property (@(posedge clk) disable iff (rst)
    misaligned |-> (taken && next_pc[1]));
  a_r9_boolean: assert property (@(posedge clk) disable iff (rst)
    op_is_set(op) |-> (result[XLEN-1:1] == '0));
  a_r13_quiet: assert property (@(posedge clk) disable iff (rst)
    (op <= 4'd6 || op >= 4'd12) |-> (result == '0));
endmodule

// File: tb/branch_pc_unit_test.sv
module branch_pc_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [31:0] rs1_val = '0, rs2_val = '0, imm = '0;
  logic [31:0] pc, next_pc, result;
  logic        taken, misaligned;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] model_pc;

  localparam logic [31:0] RV = 32'h0000_1000;

  always #2.5 clk = ~clk;

  branch_pc_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .rs1_val(rs1_val),
    .rs2_val(rs2_val), .imm(imm), .pc(pc), .taken(taken), .next_pc(next_pc),
    .result(result), .misaligned(misaligned)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (op=%0d a=%h b=%h imm=%h)",
               req, act, exp, op, rs1_val, rs2_val, imm);
    end
  endtask

  function automatic logic cond(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
    case (o)
      4'd1: return a == b;
      4'd2: return a != b;
      4'd3: return $signed(a) < $signed(b);
      4'd4: return $signed(a) >= $signed(b);
      4'd5: return a < b;
      4'd6: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] vals(input int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h0000_0002;
      3: return 32'h0000_002A;
      4: return 32'h7FFF_FFFF;
      5: return 32'h8000_0000;
      6: return 32'hFFFF_FFFE;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] imms(input int k);
    case (k % 8)
      0: return 32'd0;
      1: return 32'd1;
      2: return 32'd2;
      3: return 32'hFFFF_FFFF;
      4: return 32'hFFFF_FFFE;
      5: return 32'hFFFF_F800;
      6: return 32'h0000_07FF;
      default: return 32'd3;
    endcase
  endfunction

  task automatic apply_and_check(input logic [3:0] o, input logic [31:0] a,
                                 input logic [31:0] b, input logic [31:0] im, input logic v);
    logic        et;
    logic [31:0] enp, eres, tgt, cb;
    @(negedge clk);
    op = o; rs1_val = a; rs2_val = b; imm = im; in_valid = v;
    #1;
    chk("R2 pc register", pc, model_pc);
    et  = cond(o, a, b);
    tgt = model_pc + (im * 2);
    enp = et ? tgt : model_pc + 32'd4;
    cb  = (o == 4'd9 || o == 4'd10) ? im : b;
    case (o)
      4'd7, 4'd9:  eres = {31'd0, $signed(a) < $signed(cb)};
      4'd8, 4'd10: eres = {31'd0, a < cb};
      4'd11:       eres = model_pc + (im << 12);
      default:     eres = 32'd0;
    endcase
    if (o >= 4'd1 && o <= 4'd6) begin
      chk(o <= 2 ? "R3 eq/ne taken" : (o <= 4 ? "R4 signed taken" : "R5 unsigned taken"),
          {31'd0, taken}, {31'd0, et});
      chk(et ? "R7 target" : "R8 fallthrough", next_pc, enp);
      chk("R12 misaligned", {31'd0, misaligned}, {31'd0, et & tgt[1]});
    end else begin
      chk("R8 no-branch taken", {31'd0, taken}, 32'd0);
      chk("R8 next pc", next_pc, model_pc + 32'd4);
    end
    if (o == 4'd7 || o == 4'd8) chk("R9 set result", result, eres);
    else if (o == 4'd9 || o == 4'd10) chk("R10 imm set result", result, eres);
    else if (o == 4'd11) chk("R11 upper sum", result, eres);
    else chk("R13 result zero", result, 32'd0);
    if (v) model_pc = enp;
  endtask

  initial begin
    model_pc = RV;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 reset vector", pc, RV);
    chk("R1 not taken at reset", {31'd0, taken}, 32'd0);

    // R2: idle cycles with a taken branch on the inputs must not move pc
    op = 4'd1; rs1_val = 32'd5; rs2_val = 32'd5; imm = 32'd8; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R2 hold while idle", pc, RV);

    // main sweep over all codes and corner operands
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          apply_and_check(4'(o), vals(i), vals(j), imms(i * 3 + j + o),
                          ((i + j + o) % 5) != 0);

    // R10: unsigned immediate -1 behaves as all ones
    apply_and_check(4'd10, 32'd2, 32'd0, 32'hFFFF_FFFF, 1'b0);
    chk("R10 sltiu 2 vs -1", result, 32'd1);
    apply_and_check(4'd9, 32'd2, 32'd0, 32'hFFFF_FFFF, 1'b0);
    chk("R10 slti 2 vs -1", result, 32'd0);
    // R11: zero immediate returns pc
    apply_and_check(4'd11, 32'd0, 32'd0, 32'd0, 1'b0);
    chk("R11 zero imm", result, model_pc);

    // R6: swapped operands realise greater-than and unsigned less-or-equal
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        @(negedge clk);
        in_valid = 1'b0; rs1_val = vals(j); rs2_val = vals(i); imm = 32'd4;
        op = 4'd3;
        #1;
        chk("R6 signed greater-than", {31'd0, taken},
            {31'd0, $signed(vals(i)) > $signed(vals(j))});
        op = 4'd6;
        #1;
        chk("R6 unsigned less-or-equal", {31'd0, taken}, {31'd0, vals(i) <= vals(j)});
      end

    // R7: backward branch, then R12 misaligned target still loads pc
    apply_and_check(4'd1, 32'd7, 32'd7, 32'hFFFF_FFF8, 1'b1);
    apply_and_check(4'd1, 32'd7, 32'd7, 32'd1, 1'b1);
    apply_and_check(4'd0, 32'd0, 32'd0, 32'd0, 1'b0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule